// File: doc/BRIEF.md
# I2C Slave Register Interface

This block is a 7-bit-address I2C target. It gives a bus host byte-wide read and write access to a 256-location register space. SCL and SDA are sampled on a fast system clock, synchronized, and edge-detected. The block recognises START, repeated START and STOP conditions. It matches its device address, takes a memory-address byte, and then steps through data bytes with an auto-incrementing pointer, both for writes and for reads. SDA is returned as an open-drain pull-down enable.

The upper four device-address bits are fixed at 1001. The low three come from a writable configuration byte held inside the block. Measurement values and bias bytes arrive on input ports. Writes to writable external locations leave the block as a one-cycle strobe with address and data. Reading the high byte of a 16-bit value captures the low byte, so that a burst read returns a coherent pair.

Top module: `i2c_reg_slave`

## Requirements
- R1: After reset SDA is released, the configuration byte reads 40h, no write strobe is active, and the device address is 1001000b.
- R2: The slave acknowledges an address byte only when its upper 7 bits equal 1001 followed by configuration bits 2:0. On any other address it leaves SDA released until the next START.
- R3: A write is START, the address with R/W=0 (bit 0), a memory-address byte, then data bytes. The pointer advances by one per data byte. A data byte aimed at 10h, 11h, 61h or 62h produces exactly one ext_wr_o pulse carrying that address and byte.
- R4: A read is a write phase that sets the pointer, a repeated START, then the address with R/W=1. Bytes are returned MSB first from successive addresses, and the burst ends when the master NACKs. The read map is: 01h configuration; 0Ah/0Bh temperature high/low; 0Ch/0Dh voltage; 0Eh/0Fh current; 10h/11h charge; 61h current bias; 62h accumulation bias.
- R5: Data bytes written to the read-only locations 0Ah-0Fh, or to reserved locations, are acknowledged but produce no strobe and change nothing.
- R6: Once the pointer has advanced past FFh, further written bytes are ignored and further read bytes return FFh.
- R7: Reading the even (high) byte of a 16-bit pair in 0Ah-11h latches the pair's low byte. A read of the odd byte later in the same read phase returns the latched value, even if the input has changed. A fresh transaction returns the live value.
- R8: A data byte cut short by a STOP before its eighth clock is not committed.
- R9: In the configuration byte, bit 6 (power-on flag) can be written to 0 but never to 1. Bits 5:0 are read/write, and bit 7 always reads 0.
- R10: A new value of configuration bits 2:0 takes effect as the device address from the next START. After that the old address is not acknowledged.
- R11: The slave pulls SDA low from the fall of the eighth clock through the fall of the ninth clock, and releases it afterwards on a write. SDA never changes while SCL is high.
- R12: Reads of reserved locations within 00h-FFh return 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls SDA low (open drain) |
| meas_temp_i | input | 16 | Temperature value, read at 0Ah/0Bh |
| meas_volt_i | input | 16 | Voltage value, read at 0Ch/0Dh |
| meas_curr_i | input | 16 | Current value, read at 0Eh/0Fh |
| charge_i | input | 16 | Charge count, read at 10h/11h |
| cur_bias_i | input | 8 | Current bias byte, read at 61h |
| acc_bias_i | input | 8 | Accumulation bias byte, read at 62h |
| cfg_o | output | 8 | Configuration byte |
| ext_wr_o | output | 1 | One-cycle write strobe to an external location |
| ext_addr_o | output | 8 | Address for ext_wr_o |
| ext_data_o | output | 8 | Data for ext_wr_o |

## Verification
In a single cycle, the read engine can load the next byte from the odd half of a pair while the measurement input feeding that byte changes. Whether the snapshot or the live value wins decides what the host sees. The bench reads the current pair in one burst and changes the current input after the high byte is sent but before the low byte is loaded. It expects the old low byte, then a fresh transaction that returns the new one. A second collision is a STOP arriving partway through a byte, when the commit logic and the end-of-transfer logic both act. This is judged by the absence of a strobe.

// File: rtl/i2c_reg_slave_pkg.sv
package i2c_reg_slave_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_WR, ST_WR_ACK, ST_RD, ST_RD_ACK
  } link_state_e;

  localparam logic [7:0] A_CFG   = 8'h01;
  localparam logic [7:0] A_TEMP  = 8'h0A;
  localparam logic [7:0] A_VOLT  = 8'h0C;
  localparam logic [7:0] A_CURR  = 8'h0E;
  localparam logic [7:0] A_CHG   = 8'h10;
  localparam logic [7:0] A_CBIAS = 8'h61;
  localparam logic [7:0] A_ABIAS = 8'h62;
  localparam logic [7:0] CFG_RST = 8'h40;

  function automatic logic in_pair(input logic [7:0] a);
    return (a >= A_TEMP) && (a <= (A_CHG | 8'h01));
  endfunction

  function automatic logic ext_writable(input logic [7:0] a);
    return (a == A_CHG) || (a == (A_CHG | 8'h01)) || (a == A_CBIAS) || (a == A_ABIAS);
  endfunction
endpackage

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int PW = STAGES + 1;

  logic [1:0] raw, cur, prv;
  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    logic [PW-1:0] pipe_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q <= '1;
      else         pipe_q <= {pipe_q[PW-2:0], raw[g]};
    end
    assign cur[g] = pipe_q[PW-2];
    assign prv[g] = pipe_q[PW-1];
  end

  assign scl_o      = cur[0];
  assign sda_o      = cur[1];
  assign scl_rise_o = cur[0] & ~prv[0];
  assign scl_fall_o = ~cur[0] & prv[0];
  assign start_o    = cur[0] & prv[0] & prv[1] & ~cur[1];
  assign stop_o     = cur[0] & prv[0] & ~prv[1] & cur[1];
endmodule

// File: rtl/i2c_link.sv
module i2c_link
  import i2c_reg_slave_pkg::*;
#(
  parameter logic [3:0] DEV_HI = 4'b1001
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       scl_rise_i,
  input  logic       scl_fall_i,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic [2:0] dev_lo_i,
  input  logic [7:0] rdata_i,
  output logic       sda_oe_o,
  output logic [8:0] ptr_o,
  output logic       wr_o,
  output logic [7:0] wdata_o,
  output logic       rd_load_o,
  output logic       xfer_end_o
);
  link_state_e state_q;
  logic [7:0] sh_q;
  logic [3:0] cnt_q;
  logic [8:0] ptr_q, ptr_inc;
  logic rw_q, first_q, nack_q, oe_q;
  logic byte_done;

  assign ptr_inc    = ptr_q[8] ? ptr_q : ptr_q + 9'd1;
  assign byte_done  = scl_fall_i && (cnt_q == 4'd8);
  assign wr_o       = (state_q == ST_WR) && byte_done && !first_q;
  assign rd_load_o  = scl_fall_i && (((state_q == ST_ADDR_ACK) && rw_q) ||
                                     ((state_q == ST_RD_ACK) && !nack_q));
  assign xfer_end_o = start_i | stop_i;
  assign sda_oe_o   = oe_q;
  assign ptr_o      = ptr_q;
  assign wdata_o    = sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sh_q    <= '0;
      cnt_q   <= '0;
      ptr_q   <= '0;
      rw_q    <= 1'b0;
      first_q <= 1'b0;
      nack_q  <= 1'b0;
      oe_q    <= 1'b0;
    end else if (start_i) begin
      state_q <= ST_ADDR;
      cnt_q   <= '0;
      oe_q    <= 1'b0;
    end else if (stop_i) begin
      state_q <= ST_IDLE;
      oe_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR: begin
          if (scl_rise_i) begin
            sh_q  <= {sh_q[6:0], sda_i};
            cnt_q <= cnt_q + 4'd1;
          end else if (byte_done) begin
            if (sh_q[7:1] == {DEV_HI, dev_lo_i}) begin
              state_q <= ST_ADDR_ACK;
              oe_q    <= 1'b1;
              rw_q    <= sh_q[0];
              first_q <= 1'b1;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        ST_ADDR_ACK: if (scl_fall_i) begin
          cnt_q <= '0;
          if (rw_q) begin
            state_q <= ST_RD;
            sh_q    <= rdata_i;
            oe_q    <= ~rdata_i[7];
            ptr_q   <= ptr_inc;
          end else begin
            state_q <= ST_WR;
            oe_q    <= 1'b0;
          end
        end
        ST_WR: begin
          if (scl_rise_i) begin
            sh_q  <= {sh_q[6:0], sda_i};
            cnt_q <= cnt_q + 4'd1;
          end else if (byte_done) begin
            state_q <= ST_WR_ACK;
            oe_q    <= 1'b1;
            first_q <= 1'b0;
            ptr_q   <= first_q ? {1'b0, sh_q} : ptr_inc;
          end
        end
        ST_WR_ACK: if (scl_fall_i) begin
          state_q <= ST_WR;
          cnt_q   <= '0;
          oe_q    <= 1'b0;
        end
        ST_RD: if (scl_fall_i) begin
          cnt_q <= cnt_q + 4'd1;
          if (cnt_q == 4'd7) begin
            state_q <= ST_RD_ACK;
            oe_q    <= 1'b0;
          end else begin
            sh_q <= {sh_q[6:0], 1'b0};
            oe_q <= ~sh_q[6];
          end
        end
        ST_RD_ACK: begin
          if (scl_rise_i) nack_q <= sda_i;
          else if (scl_fall_i) begin
            if (!nack_q) begin
              state_q <= ST_RD;
              sh_q    <= rdata_i;
              oe_q    <= ~rdata_i[7];
              ptr_q   <= ptr_inc;
              cnt_q   <= '0;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  a_r11_sda_steady: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(scl_i) && !$past(start_i) && !$past(stop_i)) |-> $stable(oe_q));

  a_r2_idle_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> !oe_q);

  a_r6_ptr_stays_past_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr_q[8] && !((state_q == ST_WR) && byte_done && first_q)) |=> ptr_q[8]);
endmodule

// File: rtl/i2c_reg_map.sv
module i2c_reg_map
  import i2c_reg_slave_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [8:0]  addr_i,
  input  logic        wr_i,
  input  logic [7:0]  wdata_i,
  input  logic        rd_load_i,
  input  logic        xfer_end_i,
  input  logic [15:0] meas_temp_i,
  input  logic [15:0] meas_volt_i,
  input  logic [15:0] meas_curr_i,
  input  logic [15:0] charge_i,
  input  logic [7:0]  cur_bias_i,
  input  logic [7:0]  acc_bias_i,
  output logic [7:0]  rdata_o,
  output logic [7:0]  cfg_o,
  output logic        ext_wr_o,
  output logic [7:0]  ext_addr_o,
  output logic [7:0]  ext_data_o
);
  logic [7:0] cfg_q, snap_lo_q;
  logic [6:0] snap_pair_q;
  logic       snap_v_q;
  logic [7:0] a;
  logic       in_range;

  assign a        = addr_i[7:0];
  assign in_range = !addr_i[8];

  function automatic logic [7:0] live(input logic [7:0] x);
    unique case (x)
      A_CFG:            return cfg_q;
      A_TEMP:           return meas_temp_i[15:8];
      A_TEMP | 8'h01:   return meas_temp_i[7:0];
      A_VOLT:           return meas_volt_i[15:8];
      A_VOLT | 8'h01:   return meas_volt_i[7:0];
      A_CURR:           return meas_curr_i[15:8];
      A_CURR | 8'h01:   return meas_curr_i[7:0];
      A_CHG:            return charge_i[15:8];
      A_CHG | 8'h01:    return charge_i[7:0];
      A_CBIAS:          return cur_bias_i;
      A_ABIAS:          return acc_bias_i;
      default:          return 8'h00;
    endcase
  endfunction

  always_comb begin
    if (!in_range)                                            rdata_o = 8'hFF;
    else if (a[0] && snap_v_q && (snap_pair_q == a[7:1]))     rdata_o = snap_lo_q;
    else                                                      rdata_o = live(a);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q       <= CFG_RST;
      snap_lo_q   <= '0;
      snap_pair_q <= '0;
      snap_v_q    <= 1'b0;
      ext_wr_o    <= 1'b0;
      ext_addr_o  <= '0;
      ext_data_o  <= '0;
    end else begin
      ext_wr_o <= wr_i && in_range && ext_writable(a);
      if (wr_i) begin
        ext_addr_o <= a;
        ext_data_o <= wdata_i;
      end
      if (wr_i && in_range && (a == A_CFG))
        cfg_q <= {1'b0, cfg_q[6] & wdata_i[6], wdata_i[5:0]};
      if (xfer_end_i) snap_v_q <= 1'b0;
      else if (rd_load_i && in_range && in_pair(a) && !a[0]) begin
        snap_lo_q   <= live({a[7:1], 1'b1});
        snap_pair_q <= a[7:1];
        snap_v_q    <= 1'b1;
      end
    end
  end

  assign cfg_o = cfg_q;

  a_r9_flag_never_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$rose(cfg_q[6]));

  a_r9_top_bit_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_q[7]);

  a_r5_strobe_targets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_wr_o |-> ext_writable(ext_addr_o));
endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave #(
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] DEV_HI      = 4'b1001
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_oe_o,
  input  logic [15:0] meas_temp_i,
  input  logic [15:0] meas_volt_i,
  input  logic [15:0] meas_curr_i,
  input  logic [15:0] charge_i,
  input  logic [7:0]  cur_bias_i,
  input  logic [7:0]  acc_bias_i,
  output logic [7:0]  cfg_o,
  output logic        ext_wr_o,
  output logic [7:0]  ext_addr_o,
  output logic [7:0]  ext_data_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_c, stop_c;
  logic [8:0] ptr;
  logic wr, rd_load, xfer_end;
  logic [7:0] wdata, rdata;

  i2c_bus_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_c), .stop_o(stop_c)
  );

  i2c_link #(.DEV_HI(DEV_HI)) i_link (
    .clk_i, .rst_ni, .scl_i(scl_s), .sda_i(sda_s), .scl_rise_i(scl_rise),
    .scl_fall_i(scl_fall), .start_i(start_c), .stop_i(stop_c),
    .dev_lo_i(cfg_o[2:0]), .rdata_i(rdata), .sda_oe_o, .ptr_o(ptr),
    .wr_o(wr), .wdata_o(wdata), .rd_load_o(rd_load), .xfer_end_o(xfer_end)
  );

  i2c_reg_map i_map (
    .clk_i, .rst_ni, .addr_i(ptr), .wr_i(wr), .wdata_i(wdata),
    .rd_load_i(rd_load), .xfer_end_i(xfer_end), .meas_temp_i, .meas_volt_i,
    .meas_curr_i, .charge_i, .cur_bias_i, .acc_bias_i, .rdata_o(rdata),
    .cfg_o, .ext_wr_o, .ext_addr_o, .ext_data_o
  );
endmodule

// File: tb/test_i2c_reg_slave.sv
module test_i2c_reg_slave;
  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1, sda_bus;
  logic sda_oe, ext_wr;
  logic [7:0] cfg, ext_addr, ext_data;
  logic [15:0] temp = 16'h1234, volt = 16'h5678, curr = 16'h9ABC, chg = 16'hDEF0;
  logic [7:0] cbias = 8'h11, abias = 8'h22;
  int checks = 0, errors = 0, wr_cnt = 0;
  logic [7:0] log_a [32];
  logic [7:0] log_d [32];
  bit done = 1'b0;

  always #4 clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  i2c_reg_slave i_i2c_reg_slave (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe_o(sda_oe),
    .meas_temp_i(temp), .meas_volt_i(volt), .meas_curr_i(curr), .charge_i(chg),
    .cur_bias_i(cbias), .acc_bias_i(abias), .cfg_o(cfg), .ext_wr_o(ext_wr),
    .ext_addr_o(ext_addr), .ext_data_o(ext_data)
  );

  always @(negedge clk) if (ext_wr && wr_cnt < 32) begin
    log_a[wr_cnt] = ext_addr;
    log_d[wr_cnt] = ext_data;
    wr_cnt++;
  end

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic q();
    repeat (10) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; scl = 1'b1; q(); sda_m = 1'b0; q(); scl = 1'b0; q();
  endtask

  task automatic i2c_rstart();
    sda_m = 1'b1; q(); scl = 1'b1; q(); sda_m = 1'b0; q(); scl = 1'b0; q();
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; q(); scl = 1'b1; q(); sda_m = 1'b1; q();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; q(); scl = 1'b1; q(); q(); scl = 1'b0; q();
    end
  endtask

  // rel: slave must let go of SDA after the ninth clock (not a read-address byte)
  task automatic send_byte(input logic [7:0] b, input bit exp_ack, input bit rel);
    logic ack;
    send_bits(b, 8);
    sda_m = 1'b1;
    if (exp_ack) chk(sda_oe == 1'b1, "R11 ack early", 16'(sda_oe), 16'd1);
    q(); scl = 1'b1; q();
    ack = !sda_bus;
    chk(ack == exp_ack, "R2 ack", 16'(ack), 16'(exp_ack));
    q(); scl = 1'b0; q();
    if (rel) chk(sda_oe == 1'b0, "R11 release", 16'(sda_oe), 16'd0);
  endtask

  task automatic recv_byte(output logic [7:0] b, input bit nack, input bit swap);
    b = '0;
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      q(); scl = 1'b1; q(); b = {b[6:0], sda_bus}; q(); scl = 1'b0;
    end
    if (swap) curr = 16'h1357;
    q(); sda_m = nack; q(); scl = 1'b1; q(); q(); scl = 1'b0; q(); sda_m = 1'b1;
  endtask

  task automatic read1(input logic [7:0] dev, input logic [7:0] a, output logic [7:0] b);
    i2c_start(); send_byte({dev[6:0], 1'b0}, 1, 1); send_byte(a, 1, 1);
    i2c_rstart(); send_byte({dev[6:0], 1'b1}, 1, 0);
    recv_byte(b, 1, 0); i2c_stop();
  endtask

  // {address, expected byte}; 00h, 05h and FFh are reserved (R12)
  localparam logic [15:0] RD_VEC [14] = '{
    16'h0140, 16'h0A12, 16'h0B34, 16'h0C56, 16'h0D78, 16'h0E9A, 16'h0FBC,
    16'h10DE, 16'h11F0, 16'h6111, 16'h6222, 16'h0000, 16'h0500, 16'hFF00
  };

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%h expected=%h", 1'b0, 1'b1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] b, b2, b3, b4;
    int base;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(sda_oe == 1'b0, "R1 sda released", 16'(sda_oe), 16'd0);
    chk(cfg == 8'h40, "R1 cfg reset", 16'(cfg), 16'h40);
    chk(ext_wr == 1'b0, "R1 no strobe", 16'(ext_wr), 16'd0);

    // R4 / R12 read map table
    for (int v = 0; v < 14; v++) begin
      read1(7'h48, RD_VEC[v][15:8], b);
      chk(b == RD_VEC[v][7:0], "R4/R12 read map", 16'(b), 16'(RD_VEC[v][7:0]));
    end

    // R2 foreign address ignored
    base = wr_cnt;
    i2c_start(); send_byte(8'h92, 0, 1); send_byte(8'h10, 0, 1); i2c_stop();
    chk(wr_cnt == base, "R2 no strobe on foreign address", 16'(wr_cnt - base), 16'd0);

    // R3 burst write with auto-increment
    base = wr_cnt;
    i2c_start(); send_byte(8'h90, 1, 1); send_byte(8'h10, 1, 1);
    send_byte(8'hAA, 1, 1); send_byte(8'hBB, 1, 1); i2c_stop();
    chk(wr_cnt == base + 2, "R3 strobe count", 16'(wr_cnt - base), 16'd2);
    chk({log_a[base], log_d[base]} == 16'h10AA, "R3 first strobe", {log_a[base], log_d[base]}, 16'h10AA);
    chk({log_a[base+1], log_d[base+1]} == 16'h11BB, "R3 second strobe", {log_a[base+1], log_d[base+1]}, 16'h11BB);

    // R3 / R5 bias bytes then reserved 63h
    base = wr_cnt;
    i2c_start(); send_byte(8'h90, 1, 1); send_byte(8'h61, 1, 1);
    send_byte(8'hC1, 1, 1); send_byte(8'hC2, 1, 1); send_byte(8'hC3, 1, 1); i2c_stop();
    chk(wr_cnt == base + 2, "R5 reserved write dropped", 16'(wr_cnt - base), 16'd2);
    chk({log_a[base+1], log_d[base+1]} == 16'h62C2, "R3 bias strobe", {log_a[base+1], log_d[base+1]}, 16'h62C2);

    // R5 read-only pair
    base = wr_cnt;
    i2c_start(); send_byte(8'h90, 1, 1); send_byte(8'h0A, 1, 1);
    send_byte(8'h01, 1, 1); send_byte(8'h02, 1, 1); i2c_stop();
    chk(wr_cnt == base, "R5 read-only write dropped", 16'(wr_cnt - base), 16'd0);
    read1(7'h48, 8'h0A, b);
    chk(b == 8'h12, "R5 read-only unchanged", 16'(b), 16'h12);

    // R6 writes past FFh
    base = wr_cnt;
    i2c_start(); send_byte(8'h90, 1, 1); send_byte(8'hFF, 1, 1);
    send_byte(8'h10, 1, 1); send_byte(8'h11, 1, 1); send_byte(8'h12, 1, 1); i2c_stop();
    chk(wr_cnt == base, "R6 write past end dropped", 16'(wr_cnt - base), 16'd0);

    // R6 reads past FFh
    i2c_start(); send_byte(8'h90, 1, 1); send_byte(8'hFE, 1, 1);
    i2c_rstart(); send_byte(8'h91, 1, 0);
    recv_byte(b, 0, 0); recv_byte(b2, 0, 0); recv_byte(b3, 0, 0); recv_byte(b4, 1, 0); i2c_stop();
    chk({b, b2} == 16'h0000, "R12 reserved FEh/FFh", {b, b2}, 16'h0000);
    chk({b3, b4} == 16'hFFFF, "R6 read past end", {b3, b4}, 16'hFFFF);

    // R4 burst read
    i2c_start(); send_byte(8'h90, 1, 1); send_byte(8'h0A, 1, 1);
    i2c_rstart(); send_byte(8'h91, 1, 0);
    recv_byte(b, 0, 0); recv_byte(b2, 0, 0); recv_byte(b3, 0, 0); recv_byte(b4, 1, 0); i2c_stop();
    chk({b, b2} == 16'h1234, "R4 burst temp", {b, b2}, 16'h1234);
    chk({b3, b4} == 16'h5678, "R4 burst volt", {b3, b4}, 16'h5678);

    // R7 snapshot: current changes between high-byte send and low-byte load
    i2c_start(); send_byte(8'h90, 1, 1); send_byte(8'h0E, 1, 1);
    i2c_rstart(); send_byte(8'h91, 1, 0);
    recv_byte(b, 0, 1); recv_byte(b2, 1, 0); i2c_stop();
    chk({b, b2} == 16'h9ABC, "R7 coherent pair", {b, b2}, 16'h9ABC);
    read1(7'h48, 8'h0F, b);
    chk(b == 8'h57, "R7 fresh low byte", 16'(b), 16'h57);
    read1(7'h48, 8'h0E, b);
    chk(b == 8'h13, "R7 fresh high byte", 16'(b), 16'h13);

    // R8 byte cut short by STOP
    base = wr_cnt;
    i2c_start(); send_byte(8'h90, 1, 1); send_byte(8'h61, 1, 1);
    send_bits(8'hF0, 4); i2c_stop();
    chk(wr_cnt == base, "R8 partial byte dropped", 16'(wr_cnt - base), 16'd0);

    // R9 / R10 configuration and address change
    i2c_start(); send_byte(8'h90, 1, 1); send_byte(8'h01, 1, 1); send_byte(8'h3D, 1, 1); i2c_stop();
    chk(cfg == 8'h3D, "R9 cfg write", 16'(cfg), 16'h3D);
    i2c_start(); send_byte(8'h90, 0, 1); i2c_stop();
    i2c_start(); send_byte(8'h9A, 1, 1); send_byte(8'h01, 1, 1); send_byte(8'hFD, 1, 1); i2c_stop();
    chk(cfg == 8'h3D, "R9 flag and bit7 stay clear", 16'(cfg), 16'h3D);
    read1(7'h4D, 8'h01, b);
    chk(b == 8'h3D, "R10 read via new address", 16'(b), 16'h3D);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule